// File: doc/BRIEF.md
# Auto-Detecting Multiplexed Bus Register Loader

This block is a write-only slave on an 8-bit multiplexed address/data bus. A host places a register address on the shared lines under an address strobe, then a data byte under a write strobe. Each address cycle decides for itself which strobing convention is in use. If the read/data-strobe line is high when the address strobe rises, the cycle is Intel-style: the write strobe's rising edge stores the data. If that line is low, the cycle is Motorola-style: a falling data strobe with the read/write line low stores the data.

Bytes go into three staging registers. A write to one of two command addresses copies all three staging bytes at once into either the 24-bit control register or the 24-bit initialisation register. The byte written to a command address is discarded. The block then decodes the committed words into named fields for the waveform logic downstream. This includes the clock divisor that the carrier-divide code selects and the multiplier that the range code selects.

All bus lines are brought into the system clock with two-flop synchronisers, and edges are detected there. Each strobe phase must therefore last at least three system clocks, and the address/data lines must be held steady across each edge that samples them.

Top module: `mbl_top`

FSM states: `S_IDLE` (no cycle open), `S_ADDR` (address strobe high, bus format captured), `S_DATA` (address held, waiting for the write edge).

FSM transitions:
- `S_IDLE` goes to `S_ADDR` when the address strobe rises.
- `S_ADDR` goes to `S_DATA` when the address strobe falls, and the address is latched.
- `S_DATA` goes to `S_IDLE` on the write edge of the captured format.
- `S_DATA` goes to `S_ADDR` when a new address strobe rises.

## Requirements
- R1: After reset, `ctrl_word` and `init_word` are all zero and every decoded field reflects zero contents.
- R2: Intel-style cycle: `rd_ds` is high when `ale_as` rises, the address is taken when `ale_as` falls, and the data byte is stored on the rising edge of `wr_rw`.
- R3: Motorola-style cycle: `rd_ds` is low when `ale_as` rises, and the data byte is stored on the falling edge of `rd_ds` while `wr_rw` is low.
- R4: In a Motorola-style cycle, a falling `rd_ds` while `wr_rw` is high stores nothing.
- R5: A write edge seen while `cs_n` is high stores nothing, in either format.
- R6: Only `ad[2:0]` form the address. Codes 000, 001 and 010 select staging bytes S0, S1 and S2. Codes 100, 110 and 111 have no effect. `ad[7:3]` are ignored.
- R7: A write to code 011 loads `ctrl_word` with {S2,S1,S0}, with S0 in bits 7..0. The byte written is ignored, and the staging bytes are kept for later commits.
- R8: A write to code 101 loads `init_word` with {S2,S1,S0} in the same order, and the byte written is ignored.
- R9: Writes to staging bytes leave `ctrl_word` and `init_word` unchanged until a commit.
- R10: Control fields: `freq_word` = {S1[3:0],S0}, `reverse` = S1[7], `overmod` = S1[6], `out_enable_n` = S1[5], `amplitude` = S2.
- R11: Initialisation fields: `ctr_clear_n` = S0[7], `min_width_code` = S0[6:0], `range_code` = S1[7:5], `carrier_code` = S1[2:0], `dead_code` = S2[5:0].
- R12: `carrier_div` = 2^`carrier_code` for codes 0 to 5, and 32 for 6 and 7. `range_mult` = 2^`range_code` for codes 0 to 6, and 64 for 7.
- R13: The format is detected anew on every address cycle, so Intel-style and Motorola-style cycles may alternate freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 8 | Multiplexed address/data lines |
| ale_as | input | 1 | Address strobe, active high |
| rd_ds | input | 1 | Read strobe (Intel) or data strobe (Motorola); also picks the format |
| wr_rw | input | 1 | Write strobe (Intel) or read/write select (Motorola) |
| cs_n | input | 1 | Chip select, active low |
| ctrl_word | output | 24 | Committed control register |
| init_word | output | 24 | Committed initialisation register |
| freq_word | output | 12 | Output frequency select |
| reverse | output | 1 | Phase sequence reversed |
| overmod | output | 1 | Overmodulation enabled |
| out_enable_n | output | 1 | Output inhibit, active low |
| amplitude | output | 8 | Amplitude scale |
| ctr_clear_n | output | 1 | Phase counter clear, active low |
| min_width_code | output | 7 | Minimum pulse width code |
| range_code | output | 3 | Frequency range code |
| carrier_code | output | 3 | Carrier divide code |
| dead_code | output | 6 | Underlap delay code |
| carrier_div | output | 6 | Decoded carrier divisor |
| range_mult | output | 7 | Decoded range multiplier |

## Verification
The assertions assume that each strobe level lasts long enough for the synchronisers to see every edge. They also assume `ad`, `cs_n` and `wr_rw` do not change within a clock of the edge that samples them. Without this, a write pulse cannot be traced back to a clean chip select or read/write level. The stimulus holds every strobe phase for five clocks and changes data, select and direction only while no strobe edge is pending. It returns the direction line to its idle level only after the data strobe has settled.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NSTAGE = 3;
    localparam int WORD_W = DATA_W * NSTAGE;

    localparam logic [ADDR_W-1:0] ADR_S0   = 3'b000;
    localparam logic [ADDR_W-1:0] ADR_S1   = 3'b001;
    localparam logic [ADDR_W-1:0] ADR_S2   = 3'b010;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'b011;
    localparam logic [ADDR_W-1:0] ADR_INIT = 3'b101;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_DATA = 2'd2
    } bus_state_t;
endpackage

// File: rtl/mbl_sync.sv
module mbl_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= pipe[i-1];
        end
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/mbl_bus_fsm.sv
module mbl_bus_fsm
    import mbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic              ale_p,
    input  logic              rd_s,
    input  logic              rd_p,
    input  logic              wr_s,
    input  logic              wr_p,
    input  logic              cs_n_s,
    input  logic [DATA_W-1:0] ad_s,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    bus_state_t state, state_nx;
    logic intel_q;
    logic ale_rise, ale_fall, wr_rise, ds_fall, wr_evt, take;

    always_comb begin
        ale_rise = ale_s & ~ale_p;
        ale_fall = ~ale_s & ale_p;
        wr_rise  = wr_s & ~wr_p;
        ds_fall  = ~rd_s & rd_p;
        wr_evt   = intel_q ? wr_rise : (ds_fall & ~wr_s);
        take     = (state == S_DATA) && !ale_rise && wr_evt && !cs_n_s;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (ale_rise) state_nx = S_ADDR;
            S_ADDR: if (ale_fall) state_nx = S_DATA;
            S_DATA: begin
                if (ale_rise)    state_nx = S_ADDR;
                else if (wr_evt) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intel_q  <= 1'b1;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= take;
            if (ale_rise) intel_q <= rd_s;
            if (state == S_ADDR && ale_fall) wr_addr <= ad_s[ADDR_W-1:0];
            if (take) wr_data <= ad_s;
        end
    end

    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(state) == S_DATA); // R2
    AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !$past(cs_n_s)); // R5
    AST_MOTO_RW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !intel_q) |-> !$past(wr_s)); // R4
    AST_ADDR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && $past(state) == S_ADDR) |-> $past(ale_fall)); // R2
endmodule

// File: rtl/mbl_regfile.sv
module mbl_regfile
    import mbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] init_word
);
    logic [DATA_W-1:0] stage_q [NSTAGE];
    logic [WORD_W-1:0] staged;
    logic ld_ctrl, ld_init;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else if (wr_pulse && wr_addr == ADDR_W'(i)) stage_q[i] <= wr_data;
        end
        assign staged[i*DATA_W +: DATA_W] = stage_q[i];
    end

    always_comb begin
        ld_ctrl = wr_pulse && (wr_addr == ADR_CTRL);
        ld_init = wr_pulse && (wr_addr == ADR_INIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word <= '0;
            init_word <= '0;
        end else begin
            if (ld_ctrl) ctrl_word <= staged;
            if (ld_init) init_word <= staged;
        end
    end

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ctrl, ld_init})); // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && wr_addr == ADR_CTRL) |=> $stable(ctrl_word)); // R9
    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && wr_addr == ADR_INIT) |=> $stable(init_word)); // R9
endmodule

// File: rtl/mbl_top.sv
module mbl_top
    import mbl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  ad,
    input  logic        ale_as,
    input  logic        rd_ds,
    input  logic        wr_rw,
    input  logic        cs_n,
    output logic [23:0] ctrl_word,
    output logic [23:0] init_word,
    output logic [11:0] freq_word,
    output logic        reverse,
    output logic        overmod,
    output logic        out_enable_n,
    output logic [7:0]  amplitude,
    output logic        ctr_clear_n,
    output logic [6:0]  min_width_code,
    output logic [2:0]  range_code,
    output logic [2:0]  carrier_code,
    output logic [5:0]  dead_code,
    output logic [5:0]  carrier_div,
    output logic [6:0]  range_mult
);
    localparam int SYNC_W = DATA_W + 4;

    logic [SYNC_W-1:0] raw, syn, syn_p;
    logic              wr_pulse;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign raw = {cs_n, wr_rw, rd_ds, ale_as, ad};

    mbl_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn), .q_prev(syn_p)
    );

    mbl_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ale_s(syn[DATA_W]),   .ale_p(syn_p[DATA_W]),
        .rd_s(syn[DATA_W+1]),  .rd_p(syn_p[DATA_W+1]),
        .wr_s(syn[DATA_W+2]),  .wr_p(syn_p[DATA_W+2]),
        .cs_n_s(syn[DATA_W+3]),
        .ad_s(syn[DATA_W-1:0]),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    mbl_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_word(ctrl_word), .init_word(init_word)
    );

    always_comb begin
        freq_word      = ctrl_word[11:0];
        reverse        = ctrl_word[15];
        overmod        = ctrl_word[14];
        out_enable_n   = ctrl_word[13];
        amplitude      = ctrl_word[23:16];
        ctr_clear_n    = init_word[7];
        min_width_code = init_word[6:0];
        range_code     = init_word[15:13];
        carrier_code   = init_word[10:8];
        dead_code      = init_word[21:16];
        carrier_div    = (carrier_code > 3'd5) ? 6'd32 : (6'd1 << carrier_code);
        range_mult     = (range_code   > 3'd6) ? 7'd64 : (7'd1 << range_code);
    end

    AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(carrier_div) && $onehot(range_mult)); // R12
endmodule

// File: tb/sim_mbl_top.sv
module sim_mbl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad = '0;
    logic        ale_as = 1'b0, rd_ds = 1'b1, wr_rw = 1'b1, cs_n = 1'b1;
    logic [23:0] ctrl_word, init_word;
    logic [11:0] freq_word;
    logic        reverse, overmod, out_enable_n, ctr_clear_n;
    logic [7:0]  amplitude;
    logic [6:0]  min_width_code;
    logic [2:0]  range_code, carrier_code;
    logic [5:0]  dead_code, carrier_div;
    logic [6:0]  range_mult;

    always #4 clk = ~clk;

    mbl_top u0 (.*);

    typedef struct {
        string       req;
        logic [23:0] ctrl;
        logic [23:0] init;
    } exp_t;

    exp_t   q[$];
    event   chk_ev;
    int     checks = 0, errors = 0;
    bit     done = 0;
    logic [7:0]  m_stage [3];
    logic [23:0] m_ctrl = '0, m_init = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply(logic [7:0] a, logic [7:0] d);
        case (a[2:0])
            3'b000, 3'b001, 3'b010: m_stage[a[2:0]] = d;
            3'b011: m_ctrl = {m_stage[2], m_stage[1], m_stage[0]};
            3'b101: m_init = {m_stage[2], m_stage[1], m_stage[0]};
            default: ;
        endcase
    endtask

    task automatic post(string req);
        exp_t e;
        e.req = req; e.ctrl = m_ctrl; e.init = m_init;
        q.push_back(e);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic intel_wr(logic [7:0] a, logic [7:0] d, logic cs, string req);
        rd_ds = 1'b1; wr_rw = 1'b1; idle(4);
        ad = a; cs_n = cs; idle(2);
        ale_as = 1'b1; idle(5);
        ale_as = 1'b0; idle(5);
        ad = d; idle(2);
        wr_rw = 1'b0; idle(5);
        wr_rw = 1'b1; idle(5);
        cs_n = 1'b1; idle(2);
        if (!cs) apply(a, d);
        post(req);
    endtask

    task automatic moto_wr(logic [7:0] a, logic [7:0] d, logic rw, logic cs, string req);
        rd_ds = 1'b0; idle(4);
        wr_rw = rw; ad = a; cs_n = cs; idle(2);
        ale_as = 1'b1; idle(5);
        ale_as = 1'b0; idle(5);
        ad = d; idle(2);
        rd_ds = 1'b1; idle(5);
        rd_ds = 1'b0; idle(5);
        wr_rw = 1'b1; cs_n = 1'b1; idle(2);
        if (!cs && !rw) apply(a, d);
        post(req);
    endtask

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        exp_t e;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                e = q.pop_front();
                chk(e.req, "ctrl_word", ctrl_word, e.ctrl);
                chk(e.req, "init_word", init_word, e.init);
                chk("R10", "freq_word", freq_word, {e.ctrl[11:8], e.ctrl[7:0]});
                chk("R10", "dir/om/inh", {reverse, overmod, out_enable_n}, e.ctrl[15:13]);
                chk("R10", "amplitude", amplitude, e.ctrl[23:16]);
                chk("R11", "ctr_clear_n/min_width", {ctr_clear_n, min_width_code}, e.init[7:0]);
                chk("R11", "range/carrier", {range_code, carrier_code}, {e.init[15:13], e.init[10:8]});
                chk("R11", "dead_code", dead_code, e.init[21:16]);
                chk("R12", "carrier_div", carrier_div,
                    (e.init[10:8] > 5) ? 32 : (1 << e.init[10:8]));
                chk("R12", "range_mult", range_mult,
                    (e.init[15:13] > 6) ? 64 : (1 << e.init[15:13]));
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_stage[i] = '0;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        post("R1 reset");

        // R2 Intel staging; R9 no change before commit
        intel_wr(8'h00, 8'h66, 1'b0, "R2 R9 stage S0");
        intel_wr(8'h01, 8'hA6, 1'b0, "R2 R9 stage S1");
        intel_wr(8'h02, 8'hCC, 1'b0, "R2 R9 stage S2");
        intel_wr(8'h03, 8'h5A, 1'b0, "R7 ctrl commit");
        intel_wr(8'h03, 8'h00, 1'b0, "R7 recommit keeps staging");

        // R3 Motorola, R8 init commit
        moto_wr(8'h00, 8'hD2, 1'b0, 1'b0, "R3 stage S0");
        moto_wr(8'h01, 8'h82, 1'b0, 1'b0, "R3 stage S1");
        moto_wr(8'h02, 8'h30, 1'b0, 1'b0, "R3 stage S2");
        moto_wr(8'h05, 8'hFF, 1'b0, 1'b0, "R8 init commit");

        // R4 read cycles store nothing
        moto_wr(8'h00, 8'h11, 1'b1, 1'b0, "R4 rw high");
        moto_wr(8'h03, 8'h00, 1'b1, 1'b0, "R4 rw high commit");
        moto_wr(8'h03, 8'h00, 1'b0, 1'b0, "R4 staging intact");

        // R5 chip select high
        intel_wr(8'h01, 8'h0F, 1'b1, "R5 intel cs high");
        moto_wr(8'h02, 8'h77, 1'b0, 1'b1, "R5 moto cs high");
        intel_wr(8'h05, 8'h00, 1'b1, "R5 commit cs high");
        intel_wr(8'h03, 8'h00, 1'b0, "R5 staging intact");

        // R6 unused codes and upper address bits
        intel_wr(8'h04, 8'h99, 1'b0, "R6 code 100");
        moto_wr(8'h06, 8'h98, 1'b0, 1'b0, "R6 code 110");
        intel_wr(8'h07, 8'h97, 1'b0, "R6 code 111");
        intel_wr(8'hF9, 8'hE5, 1'b0, "R6 upper bits ignored");
        moto_wr(8'hFB, 8'h12, 1'b0, 1'b0, "R6 R7 commit alias");

        // R13 alternating formats
        for (int i = 0; i < 4; i++) begin
            if (i[0]) moto_wr(8'h00, 8'(8'h20 + i), 1'b0, 1'b0, "R13 moto");
            else      intel_wr(8'h00, 8'(8'h40 + i), 1'b0, "R13 intel");
        end
        intel_wr(8'h05, 8'h00, 1'b0, "R13 R8 init commit");

        // R12 every carrier and range code
        for (int c = 0; c < 8; c++) begin
            moto_wr(8'h01, {3'(c), 2'b00, 3'(c)}, 1'b0, 1'b0, "R12 stage code");
            intel_wr(8'h05, 8'h00, 1'b0, "R12 decode");
        end

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule